// File: doc/BRIEF.md
# Handshake Bus Interconnect for One Master and Twelve Slaves

This block joins a single processor-style master to a set of memory-mapped slaves. The master drives a 16-bit address, a 16-bit write word and a direction bit, then raises a request line. The upper byte of the address picks one slave page. The interconnect registers that choice and raises the matching slave select. The shared address, write word and direction bit fan out to every slave from registers.

The selected slave answers by raising its own acknowledge once its response is ready. It may take as many cycles as it needs, so the master sees wait states. The interconnect registers the acknowledge and the chosen slave's read word and returns them to the master. The master then drops its request. The interconnect drops the select, and the slave drops its acknowledge in turn.

Read data comes back through a decoded AND-OR multiplexer, so no bus has tristates. A request to a page that no slave owns gets an answer from the interconnect itself: read data of zero and a single-cycle error flag. All master-side and slave-side outputs come from registers, so no combinational path runs from the request to a response.

Top module: `hsbus_xbar`

## Requirements
- R1: While reset is held, sSel, mAck, mErr and mRData are all zero.
- R2: When the interconnect is idle, mReq is high and every slave acknowledge is low, the next clock edge takes in the request. If the upper address byte is a number i below 12, then after that edge sSel is one-hot with bit i set. At the same time sAddr, sWData and sWr show the values the master drove.
- R3: From the moment a select is raised until it falls, sSel, sAddr, sWData and sWr stay unchanged, even when the master changes mAddr, mWData or mWr.
- R4: While the selected slave's acknowledge stays low, mAck stays low, so wait states have no limit. One clock edge after that acknowledge is seen high, mAck is high and mRData equals that slave's read word.
- R5: An acknowledge raised by a slave that is not selected has no effect on mAck or mRData.
- R6: Once mAck is high, it stays high until mReq is low at a clock edge. After that edge mAck and sSel are both low, and mRData keeps its value.
- R7: No new select is raised while any slave acknowledge is high, even when mReq is high.
- R8: A request whose upper address byte is 12 or more raises no select. After the capturing edge, mAck and mErr are high and mRData is zero. mErr is high for exactly one cycle, and mAck stays high until mReq falls.
- R9: No output changes between clock edges in response to a change on mReq, mAddr, mWData or mWr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mReq | input | 1 | Master request |
| mWr | input | 1 | Master direction, 1 means write |
| mAddr | input | 16 | Master address |
| mWData | input | 16 | Master write word |
| mRData | output | 16 | Read word returned to the master |
| mAck | output | 1 | Acknowledge to the master |
| mErr | output | 1 | One-cycle flag for an unmapped page |
| sSel | output | 12 | One select per slave |
| sAddr | output | 16 | Captured address, shared by all slaves |
| sWData | output | 16 | Captured write word, shared by all slaves |
| sWr | output | 1 | Captured direction, shared by all slaves |
| sRData | input | 192 | Read words of all slaves, slave i at bits 16*i+15 to 16*i |
| sAck | input | 12 | Slave acknowledges, bit i from slave i |

## Verification
A wrong slave index or a dropped select bit shows on sSel one cycle after the request is taken in. A reference model that runs alongside the design flags it at that point, before any data returns. A wrong state in the handshake controller shows within one cycle as mAck rising too early, staying high after the request falls, or never rising. A wait that never ends is also caught. A wrong captured address or a broken read multiplexer shows as the wrong mRData in the cycle mAck rises. Reading back words written earlier into each slave's register-file model exposes this.

// File: rtl/hsbus_pkg.sv
package hsbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;  // take in address, write word, direction, slave index
    logic capRsp;  // load selected slave's read word
    logic clrRsp;  // force read word to zero (unmapped page)
  } busStrobe_t;

endpackage

// File: rtl/hsbus_dpath.sv
module hsbus_dpath
  import hsbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int NUM_SLV   = 12,
  parameter int PAGE_W    = 8,
  parameter int BASE_PAGE = 0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  busStrobe_t                strb,
  input  logic [ADDR_W-1:0]         mAddr,
  input  logic [DATA_W-1:0]         mWData,
  input  logic                      mWr,
  input  logic [NUM_SLV*DATA_W-1:0] sRData,
  input  logic [NUM_SLV-1:0]        sAck,
  output logic [ADDR_W-1:0]         sAddr,
  output logic [DATA_W-1:0]         sWData,
  output logic                      sWr,
  output logic [DATA_W-1:0]         mRData,
  output logic                      hitMapped,
  output logic                      selAck,
  output logic [NUM_SLV-1:0]        selVec
);

  localparam int IDX_W = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1;

  logic [PAGE_W-1:0] pageNum;
  logic [PAGE_W-1:0] pageRel;
  logic [IDX_W-1:0]  idxQ;
  logic [DATA_W-1:0] rdMux;
  logic [DATA_W-1:0] slvWord [NUM_SLV];

  // page decode on the live master address
  assign pageNum   = mAddr[ADDR_W-1 -: PAGE_W];
  assign pageRel   = pageNum - PAGE_W'(BASE_PAGE);
  assign hitMapped = (pageNum >= PAGE_W'(BASE_PAGE)) &&
                     ({1'b0, pageRel} < (PAGE_W+1)'(NUM_SLV));

  // one-hot view of the captured index, and word split of the read bus
  for (genvar g = 0; g < NUM_SLV; g++) begin : gSlv
    assign selVec[g]  = (idxQ == IDX_W'(g));
    assign slvWord[g] = sRData[g*DATA_W +: DATA_W];
  end

  // AND-OR read multiplexer
  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_SLV; i++) begin
      rdMux |= slvWord[i] & {DATA_W{selVec[i]}};
    end
  end

  assign selAck = |(selVec & sAck);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ   <= '0;
      sAddr  <= '0;
      sWData <= '0;
      sWr    <= 1'b0;
      mRData <= '0;
    end else begin
      if (strb.capReq) begin
        idxQ   <= pageRel[IDX_W-1:0];
        sAddr  <= mAddr;
        sWData <= mWData;
        sWr    <= mWr;
      end
      if (strb.clrRsp) begin
        mRData <= '0;
      end else if (strb.capRsp) begin
        mRData <= rdMux;
      end
    end
  end

endmodule

// File: rtl/hsbus_ctrl.sv
module hsbus_ctrl
  import hsbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       mReq,
  input  logic       hitMapped,
  input  logic       selAck,
  input  logic       anyAck,
  output busStrobe_t strb,
  output logic       selEn,
  output logic       mAck,
  output logic       mErr
);

  busState_t stQ;

  always_comb begin
    strb = '0;
    case (stQ)
      ST_IDLE: begin
        if (mReq && !anyAck) begin
          strb.capReq = 1'b1;
          strb.clrRsp = !hitMapped;
        end
      end
      ST_WAIT: strb.capRsp = selAck;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      selEn <= 1'b0;
      mAck  <= 1'b0;
      mErr  <= 1'b0;
    end else begin
      case (stQ)
        ST_IDLE: begin
          if (strb.capReq) begin
            if (hitMapped) begin
              stQ   <= ST_WAIT;
              selEn <= 1'b1;
            end else begin
              stQ  <= ST_DONE;
              mAck <= 1'b1;
              mErr <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (selAck) begin
            stQ  <= ST_DONE;
            mAck <= 1'b1;
          end
        end
        ST_DONE: begin
          mErr <= 1'b0;
          if (!mReq) begin
            stQ   <= ST_IDLE;
            mAck  <= 1'b0;
            selEn <= 1'b0;
          end
        end
        default: stQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hsbus_xbar.sv
module hsbus_xbar
  import hsbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int NUM_SLV   = 12,
  parameter int PAGE_W    = 8,
  parameter int BASE_PAGE = 0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      mReq,
  input  logic                      mWr,
  input  logic [ADDR_W-1:0]         mAddr,
  input  logic [DATA_W-1:0]         mWData,
  output logic [DATA_W-1:0]         mRData,
  output logic                      mAck,
  output logic                      mErr,
  output logic [NUM_SLV-1:0]        sSel,
  output logic [ADDR_W-1:0]         sAddr,
  output logic [DATA_W-1:0]         sWData,
  output logic                      sWr,
  input  logic [NUM_SLV*DATA_W-1:0] sRData,
  input  logic [NUM_SLV-1:0]        sAck
);

  busStrobe_t        strb;
  logic              hitMapped;
  logic              selAck;
  logic              selEn;
  logic [NUM_SLV-1:0] selVec;

  hsbus_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SLV(NUM_SLV),
    .PAGE_W(PAGE_W), .BASE_PAGE(BASE_PAGE)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .mAddr(mAddr), .mWData(mWData), .mWr(mWr),
    .sRData(sRData), .sAck(sAck),
    .sAddr(sAddr), .sWData(sWData), .sWr(sWr),
    .mRData(mRData), .hitMapped(hitMapped),
    .selAck(selAck), .selVec(selVec)
  );

  hsbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mReq(mReq),
    .hitMapped(hitMapped), .selAck(selAck), .anyAck(|sAck),
    .strb(strb), .selEn(selEn), .mAck(mAck), .mErr(mErr)
  );

  assign sSel = selVec & {NUM_SLV{selEn}};

endmodule

// File: rtl/hsbus_xbar_chk.sv
module hsbus_xbar_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int NUM_SLV = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               mReq,
  input logic [DATA_W-1:0]  mRData,
  input logic               mAck,
  input logic               mErr,
  input logic [NUM_SLV-1:0] sSel,
  input logic [ADDR_W-1:0]  sAddr,
  input logic [DATA_W-1:0]  sWData,
  input logic               sWr,
  input logic [NUM_SLV-1:0] sAck
);

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sSel));

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|sSel) |=> (sSel == $past(sSel)) || (sSel == '0));

  // R3
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|sSel) |=> (sSel == '0) || ($stable(sAddr) && $stable(sWData) && $stable(sWr)));

  // R4
  ack_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(mAck) && !mErr) |-> $past(|(sSel & sAck)));

  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mAck && !mReq) |=> (!mAck && (sSel == '0)));

  // R7
  sel_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|sSel) |-> ($past(sAck == '0) && $past(mReq)));

  // R8
  err_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    mErr |-> (mAck && (mRData == '0) && (sSel == '0)));

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    mErr |=> !mErr);

endmodule

bind hsbus_xbar hsbus_xbar_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SLV(NUM_SLV)
) u_chk (
  .clk(clk), .rstN(rstN), .mReq(mReq), .mRData(mRData),
  .mAck(mAck), .mErr(mErr), .sSel(sSel), .sAddr(sAddr),
  .sWData(sWData), .sWr(sWr), .sAck(sAck)
);

// File: tb/hsbus_xbar_tb.sv
module hsbus_xbar_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          mReq = 1'b0;
  logic          mWr = 1'b0;
  logic [15:0]   mAddr = '0;
  logic [15:0]   mWData = '0;
  logic [15:0]   mRData;
  logic          mAck, mErr;
  logic [NS-1:0] sSel;
  logic [15:0]   sAddr, sWData;
  logic          sWr;
  logic [NS*DW-1:0] sRData;
  logic [NS-1:0] sAck, slvAck;
  logic [NS-1:0] inj = '0;

  int nChk = 0;
  int nFail = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sAck = slvAck | inj;

  hsbus_xbar u_dut (
    .clk(clk), .rstN(rstN), .mReq(mReq), .mWr(mWr), .mAddr(mAddr),
    .mWData(mWData), .mRData(mRData), .mAck(mAck), .mErr(mErr),
    .sSel(sSel), .sAddr(sAddr), .sWData(sWData), .sWr(sWr),
    .sRData(sRData), .sAck(sAck)
  );

  // register-file slave models, slave i waits i%4 extra cycles
  for (genvar g = 0; g < NS; g++) begin : gSlave
    logic [15:0] mem [16];
    logic [15:0] rdR;
    logic        ackR;
    int          cnt;
    assign sRData[g*DW +: DW] = rdR;
    assign slvAck[g] = ackR;
    always @(posedge clk) begin
      if (!rstN) begin
        ackR <= 1'b0; rdR <= '0; cnt <= 0;
        for (int k = 0; k < 16; k++) mem[k] <= 16'(g * 16'h0101 + k);
      end else if (!sSel[g]) begin
        ackR <= 1'b0; cnt <= 0;
      end else if (!ackR) begin
        if (cnt == g % 4) begin
          ackR <= 1'b1;
          if (sWr) mem[sAddr[3:0]] <= sWData;
          else     rdR <= mem[sAddr[3:0]];
        end else begin
          cnt <= cnt + 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model, advanced at each edge from pre-edge values
  int          phase = 0;
  int          idx = 0;
  logic        expAck = 1'b0, expErr = 1'b0;
  logic [15:0] expRData = '0;
  logic [NS-1:0] expSel = '0;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      phase = 0; expAck = 0; expErr = 0; expRData = '0; expSel = '0;
    end else begin
      case (phase)
        0: if (mReq && sAck == '0) begin
             if (int'(mAddr[15:8]) < NS) begin
               idx = int'(mAddr[15:8]); expSel = NS'(1) << idx; phase = 1;
             end else begin
               expAck = 1; expErr = 1; expRData = '0; phase = 2;
             end
           end
        1: if (sAck[idx]) begin
             expAck = 1; expRData = sRData[idx*DW +: DW]; phase = 2;
           end
        default: begin
             expErr = 0;
             if (!mReq) begin phase = 0; expAck = 0; expSel = '0; end
           end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk("R4 model mAck", 32'(mAck), 32'(expAck));
      chk("R8 model mErr", 32'(mErr), 32'(expErr));
      chk("R4 model mRData", 32'(mRData), 32'(expRData));
      chk("R2 model sSel", 32'(sSel), 32'(expSel));
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  task automatic xfer(input logic [15:0] a, input logic wr, input logic [15:0] wd,
                      output logic [15:0] rd, output logic errF);
    @(negedge clk);
    mAddr = a; mWr = wr; mWData = wd; mReq = 1'b1;
    #1;
    chk("R9 no comb sSel", 32'(sSel), 32'(0));
    chk("R9 no comb mAck", 32'(mAck), 32'(0));
    @(negedge clk);
    if (int'(a[15:8]) < NS) begin
      chk("R2 select", 32'(sSel), 32'(NS'(1) << a[15:8]));
      chk("R2 sAddr", 32'(sAddr), 32'(a));
      chk("R2 sWr/sWData", {15'd0, sWr, sWData}, {15'd0, wr, wd});
    end else begin
      chk("R8 no select", 32'(sSel), 32'(0));
    end
    while (!mAck) @(negedge clk);
    rd = mRData; errF = mErr;
    mReq = 1'b0;
    @(negedge clk);
    chk("R6 ack drop", {30'd0, mAck, |sSel}, 32'(0));
    chk("R6 rdata hold", 32'(mRData), 32'(rd));
    while (sAck != '0) @(negedge clk);
  endtask

  logic [15:0] rd;
  logic        ef;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {13'd0, mAck, mErr, |sSel, mRData}, 32'(0));
    rstN = 1'b1;

    // writes then reads across slaves with different latencies
    xfer(16'h0005, 1'b1, 16'h1234, rd, ef);
    xfer(16'h0B0F, 1'b1, 16'hBEEF, rd, ef);
    xfer(16'h0502, 1'b1, 16'h5A5A, rd, ef);
    xfer(16'h0005, 1'b0, 16'h0000, rd, ef);
    chk("R4 read slave0", 32'(rd), 32'h1234);
    xfer(16'h0B0F, 1'b0, 16'h0000, rd, ef);
    chk("R4 read slave11", 32'(rd), 32'hBEEF);
    xfer(16'h0502, 1'b0, 16'h0000, rd, ef);
    chk("R4 read slave5", {15'd0, ef, rd}, 32'h5A5A);
    xfer(16'h0303, 1'b0, 16'h0000, rd, ef);
    chk("R4 reset content slave3", 32'(rd), 32'(16'h0303 + 3));

    // R3: master inputs change while slave 7 is still working
    xfer(16'h0702, 1'b1, 16'h7777, rd, ef);
    @(negedge clk);
    mAddr = 16'h0702; mWr = 1'b0; mWData = '0; mReq = 1'b1;
    @(negedge clk);
    mAddr = 16'h0109; mWr = 1'b1; mWData = 16'hFFFF;
    @(negedge clk);
    chk("R3 sel held", 32'(sSel), 32'(NS'(1) << 7));
    chk("R3 fwd held", {15'd0, sWr, sAddr}, 32'h0702);
    while (!mAck) @(negedge clk);
    chk("R3 read uses held addr", 32'(mRData), 32'h7777);
    mReq = 1'b0;
    @(negedge clk);
    while (sAck != '0) @(negedge clk);

    // R5: foreign ack while slave 7 selected
    @(negedge clk);
    mAddr = 16'h0702; mWr = 1'b0; mReq = 1'b1;
    @(negedge clk);
    inj = NS'(1) << 3;
    @(negedge clk);
    chk("R5 foreign ack ignored", {31'd0, mAck}, 32'(0));
    inj = '0;
    while (!mAck) @(negedge clk);
    chk("R5 data from selected", 32'(mRData), 32'h7777);
    mReq = 1'b0;
    @(negedge clk);
    while (sAck != '0) @(negedge clk);

    // R7: stale ack blocks a new select
    @(negedge clk);
    inj = NS'(1) << 2;
    mAddr = 16'h0005; mWr = 1'b0; mReq = 1'b1;
    @(negedge clk);
    chk("R7 blocked 1", 32'(sSel), 32'(0));
    @(negedge clk);
    chk("R7 blocked 2", 32'(sSel), 32'(0));
    inj = '0;
    @(negedge clk);
    chk("R7 select after release", 32'(sSel), 32'(1));
    while (!mAck) @(negedge clk);
    chk("R7 read", 32'(mRData), 32'h1234);
    mReq = 1'b0;
    @(negedge clk);
    while (sAck != '0) @(negedge clk);

    // R8: unmapped pages
    xfer(16'h0C10, 1'b0, 16'h0000, rd, ef);
    chk("R8 err page 0x0C", {15'd0, ef, rd}, 32'h0001_0000);
    @(negedge clk);
    mAddr = 16'hFF00; mReq = 1'b1;
    @(negedge clk);
    chk("R8 first cycle", {29'd0, mAck, mErr, |sSel}, 32'b110);
    @(negedge clk);
    chk("R8 err one cycle, ack held", {29'd0, mAck, mErr, |sSel}, 32'b100);
    chk("R6 ack held while req", {31'd0, mAck}, 32'(1));
    mReq = 1'b0;
    @(negedge clk);
    chk("R6 ack released", {31'd0, mAck}, 32'(0));

    // back-to-back after error still works
    xfer(16'h0B0F, 1'b0, 16'h0000, rd, ef);
    chk("R4 read after error", {15'd0, ef, rd}, 32'hBEEF);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule